// File: doc/BRIEF.md
# Port Transfer Control and Status Register

This block is the byte-wide control and status register of one parallel I/O port as a host bus sees it. It keeps a data-ready flag for the port data byte and a transfer flag that is raised with it. It holds a handshake enable bit and a forced-interrupt flag. It also has a peripheral-interrupt bit, which serves as both the enable and the pending status for edges on an external interrupt line.

The external line is brought into the clock domain through a synchroniser. It is then compared against a registered copy to find an edge, and a polarity input selects whether rising or falling edges count. The flags clear in different ways. Data-ready and transfer clear when the port data register is read. Forced clears when this register is read. The peripheral bit clears only when a 0 is written to it. An interrupt request output merges the enabled conditions.

Top module: `xfer_ctl_reg`

## Requirements
- R1: When `sel` is 1, `rdata` shows bit 7 = peripheral pending, bit 6 = forced flag, bit 5 = transfer flag, bits 4..2 = 0, bit 1 = handshake enable, bit 0 = data ready. When `sel` is 0, `rdata` is 0.
- R2: The data-ready flag becomes 1 on the clock edge at which `rdy_evt` is 1. It becomes 0 on an edge with `data_rd` = 1 and `rdy_evt` = 0. When both are 1, the flag is set.
- R3: The transfer flag follows the same rule as R2: it is set by `rdy_evt`, cleared by `data_rd`, and the set wins.
- R4: A write (`sel` and `wr_en`) loads `wdata[1]` into the handshake enable. Its value appears on `hs_en` and in `rdata[1]`.
- R5: The forced flag sets on an edge where every bit of `force_bits` is 1. It clears on an edge with `sel` and `rd_en` both 1 and `force_bits` not all 1.
- R6: A write with `wdata[7]`=1 enables peripheral interrupts and leaves the pending flag unchanged. A write with `wdata[7]`=0 disables them and clears the pending flag. This clear wins over an edge detected in the same cycle.
- R7: With `pol_fall`=0 a rising transition on `periph_in` is an edge; with `pol_fall`=1 a falling one is. The pending flag becomes 1 on the third clock edge after the line changes (two synchroniser stages plus the compare register). This happens only if peripheral interrupts were enabled on that edge. A transition in the other direction does nothing.
- R8: `irq` is 1 exactly when one of these holds: the transfer flag is 1 while `xfer_irq_mode` and `glb_ie` are both 1; the forced flag is 1; or the pending flag is 1 while peripheral interrupts are enabled.
- R9: Writes to bits 6..2 and bit 0 have no effect. Only bits 7 and 1 are writable.
- R10: Synchronous `rst` clears every flag, the peripheral enable, the handshake enable and the synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 1 | Register select from the bus decoder |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe of this register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| data_rd | input | 1 | Host read of the port data register |
| rdy_evt | input | 1 | Port data byte has become ready |
| force_bits | input | FORCE_N | Force-interrupt conditions; all 1 forces an interrupt |
| xfer_irq_mode | input | 1 | Port is in interrupt-driven transfer mode |
| glb_ie | input | 1 | Global interrupt enable |
| periph_in | input | 1 | Asynchronous peripheral interrupt line |
| pol_fall | input | 1 | 0 = rising edge, 1 = falling edge |
| hs_en | output | 1 | Handshake enable |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: two synchroniser stages and a three-bit force vector. This makes the three-cycle edge latency and the all-ones force condition short enough to reach often in random traffic. Random cycles mix bus writes, register reads, data-read strobes and ready events, so same-cycle set and clear collisions occur many times. The peripheral line toggles freely under rising polarity. Directed steps cover falling polarity, a clear that coincides with an edge, and the gating of the transfer interrupt by mode and global enable.

// File: rtl/xfer_ctl_pkg.sv
package xfer_ctl_pkg;
  localparam int REG_W  = 8;
  localparam int BIT_DRR = 0;
  localparam int BIT_HE  = 1;
  localparam int BIT_TI  = 5;
  localparam int BIT_FI  = 6;
  localparam int BIT_PI  = 7;

  typedef struct packed {
    logic pi_pend;
    logic fi;
    logic ti;
    logic he;
    logic drr;
  } ctl_view_t;

  // Place the visible flags at their bit positions; unused bits are zero.
  function automatic logic [REG_W-1:0] pack_view(ctl_view_t f);
    logic [REG_W-1:0] v;
    v          = '0;
    v[BIT_PI]  = f.pi_pend;
    v[BIT_FI]  = f.fi;
    v[BIT_TI]  = f.ti;
    v[BIT_HE]  = f.he;
    v[BIT_DRR] = f.drr;
    return v;
  endfunction

  // Merge the interrupt sources into one request.
  function automatic logic irq_merge(logic ti, logic fi, logic pend, logic en,
                                     logic mode, logic gie);
    return (ti & mode & gie) | fi | (pend & en);
  endfunction
endpackage

// File: rtl/xfer_flag.sv
module xfer_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= 1'b0;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end
endmodule

// File: rtl/xfer_sync_edge.sv
module xfer_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  input  logic fall_sel,
  output logic hit_o
);
  logic [STAGES-1:0] chain;
  logic              norm_prev;
  logic              norm_now;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= line_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign norm_now = chain[STAGES-1] ^ fall_sel;

  always_ff @(posedge clk) begin
    if (rst) norm_prev <= 1'b0;
    else     norm_prev <= norm_now;
  end

  assign hit_o = norm_now & ~norm_prev;
endmodule

// File: rtl/xfer_ctl_reg.sv
module xfer_ctl_reg
  import xfer_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FORCE_N     = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [REG_W-1:0]   wdata,
  output logic [REG_W-1:0]   rdata,
  input  logic               data_rd,
  input  logic               rdy_evt,
  input  logic [FORCE_N-1:0] force_bits,
  input  logic               xfer_irq_mode,
  input  logic               glb_ie,
  input  logic               periph_in,
  input  logic               pol_fall,
  output logic               hs_en,
  output logic               irq
);
  localparam int NFLAG = 3;
  localparam int F_DRR = 0;
  localparam int F_TI  = 1;
  localparam int F_FI  = 2;

  // Named internal events, observed by the checker.
  logic reg_wr, reg_rd, force_hit, edge_hit;
  logic drr_q, ti_q, fi_q, pi_en_q, pi_pend_q, he_q;
  logic [NFLAG-1:0] flag_set, flag_clr, flag_q;

  assign reg_wr    = sel & wr_en;
  assign reg_rd    = sel & rd_en;
  assign force_hit = &force_bits;

  assign flag_set[F_DRR] = rdy_evt;
  assign flag_clr[F_DRR] = data_rd;
  assign flag_set[F_TI]  = rdy_evt;
  assign flag_clr[F_TI]  = data_rd;
  assign flag_set[F_FI]  = force_hit;
  assign flag_clr[F_FI]  = reg_rd;

  genvar i;
  generate
    for (i = 0; i < NFLAG; i++) begin : g_flag
      xfer_flag u_flag (
        .clk   (clk),
        .rst   (rst),
        .set_i (flag_set[i]),
        .clr_i (flag_clr[i]),
        .q     (flag_q[i])
      );
    end
  endgenerate

  assign drr_q = flag_q[F_DRR];
  assign ti_q  = flag_q[F_TI];
  assign fi_q  = flag_q[F_FI];

  xfer_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .line_i   (periph_in),
    .fall_sel (pol_fall),
    .hit_o    (edge_hit)
  );

  // Handshake enable and peripheral enable: the writable bits.
  always_ff @(posedge clk) begin
    if (rst) begin
      he_q    <= 1'b0;
      pi_en_q <= 1'b0;
    end else if (reg_wr) begin
      he_q    <= wdata[BIT_HE];
      pi_en_q <= wdata[BIT_PI];
    end
  end

  // Peripheral pending: cleared by writing 0, which dominates a new edge.
  always_ff @(posedge clk) begin
    if (rst)                            pi_pend_q <= 1'b0;
    else if (reg_wr && !wdata[BIT_PI])  pi_pend_q <= 1'b0;
    else if (edge_hit && pi_en_q)       pi_pend_q <= 1'b1;
  end

  ctl_view_t view;
  assign view  = '{pi_pend: pi_pend_q, fi: fi_q, ti: ti_q, he: he_q, drr: drr_q};
  assign rdata = sel ? pack_view(view) : '0;
  assign hs_en = he_q;
  assign irq   = irq_merge(ti_q, fi_q, pi_pend_q, pi_en_q, xfer_irq_mode, glb_ie);
endmodule

// File: rtl/xfer_ctl_chk.sv
module xfer_ctl_chk #(
  parameter int FORCE_N = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               sel,
  input logic               wr_en,
  input logic [7:0]         wdata,
  input logic [7:0]         rdata,
  input logic               data_rd,
  input logic               rdy_evt,
  input logic [FORCE_N-1:0] force_bits,
  input logic               reg_rd,
  input logic               irq,
  input logic               hs_en,
  input logic               drr_q,
  input logic               ti_q,
  input logic               fi_q,
  input logic               pi_en_q,
  input logic               pi_pend_q,
  input logic               edge_hit
);
  a_r1_unused_zero: assert property (@(posedge clk) disable iff (rst)
    rdata[4:2] == 3'b000);
  a_r1_idle_bus: assert property (@(posedge clk) disable iff (rst)
    !sel |-> rdata == 8'h00);
  a_r2_drr_set: assert property (@(posedge clk) disable iff (rst)
    rdy_evt |=> drr_q);
  a_r2_drr_clr: assert property (@(posedge clk) disable iff (rst)
    (data_rd && !rdy_evt) |=> !drr_q);
  a_r3_ti_set: assert property (@(posedge clk) disable iff (rst)
    rdy_evt |=> ti_q);
  a_r4_he_load: assert property (@(posedge clk) disable iff (rst)
    (sel && wr_en) |=> hs_en == $past(wdata[1]));
  a_r5_fi_set: assert property (@(posedge clk) disable iff (rst)
    (&force_bits) |=> fi_q);
  a_r5_fi_clr: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !(&force_bits)) |=> !fi_q);
  a_r6_pi_write0: assert property (@(posedge clk) disable iff (rst)
    (sel && wr_en && !wdata[7]) |=> (!pi_pend_q && !pi_en_q));
  a_r7_pend_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(pi_pend_q) |-> ($past(edge_hit) && $past(pi_en_q)));
  a_r8_quiet: assert property (@(posedge clk) disable iff (rst)
    (!ti_q && !fi_q && !pi_pend_q) |-> !irq);
  a_r8_forced: assert property (@(posedge clk) disable iff (rst)
    fi_q |-> irq);
  a_r10_reset: assert property (@(posedge clk)
    rst |=> (!drr_q && !ti_q && !fi_q && !pi_pend_q && !pi_en_q && !hs_en));
endmodule

bind xfer_ctl_reg xfer_ctl_chk #(.FORCE_N(FORCE_N)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sel        (sel),
  .wr_en      (wr_en),
  .wdata      (wdata),
  .rdata      (rdata),
  .data_rd    (data_rd),
  .rdy_evt    (rdy_evt),
  .force_bits (force_bits),
  .reg_rd     (reg_rd),
  .irq        (irq),
  .hs_en      (hs_en),
  .drr_q      (drr_q),
  .ti_q       (ti_q),
  .fi_q       (fi_q),
  .pi_en_q    (pi_en_q),
  .pi_pend_q  (pi_pend_q),
  .edge_hit   (edge_hit)
);

// File: tb/sim_xfer_ctl_reg.sv
`timescale 1ns/1ps
module sim_xfer_ctl_reg;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, sel, wr_en, rd_en, data_rd, rdy_evt, mode, gie, pin, pol;
  logic [7:0] wdata;
  logic [2:0] force_bits;
  logic [7:0] rdata;
  logic hs_en, irq;

  xfer_ctl_reg u0 (
    .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .data_rd(data_rd), .rdy_evt(rdy_evt),
    .force_bits(force_bits), .xfer_irq_mode(mode), .glb_ie(gie),
    .periph_in(pin), .pol_fall(pol), .hs_en(hs_en), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // Bench model of the register state.
  logic m_drr, m_ti, m_fi, m_he, m_en, m_pend;
  logic h1, h2, h3;   // line value one, two, three cycles back

  function automatic logic [7:0] view_of(logic s, logic pend, logic fi, logic ti,
                                         logic he, logic drr);
    if (!s) return 8'h00;
    return {pend, fi, ti, 3'b000, he, drr};
  endfunction

  function automatic logic want_irq(logic ti, logic fi, logic pend, logic en,
                                    logic md, logic ge);
    if (fi) return 1'b1;
    if (pend && en) return 1'b1;
    if (ti && md && ge) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic idle();
    sel = 0; wr_en = 0; rd_en = 0; wdata = 0; data_rd = 0; rdy_evt = 0;
    force_bits = 0;
  endtask

  // Compare outputs against the model, then advance the model over one edge.
  task automatic cyc(string tag);
    logic hit, nrm2, nrm3;
    #1;
    chk({tag, " R1 rdata"}, rdata, view_of(sel, m_pend, m_fi, m_ti, m_he, m_drr));
    chk({tag, " R8 irq"}, {7'b0, irq}, {7'b0, want_irq(m_ti, m_fi, m_pend, m_en, mode, gie)});
    chk({tag, " R4 hs_en"}, {7'b0, hs_en}, {7'b0, m_he});
    @(posedge clk);
    if (rst) begin
      {m_drr, m_ti, m_fi, m_he, m_en, m_pend, h1, h2, h3} = '0;
    end else begin
      nrm2 = h2 ^ pol; nrm3 = h3 ^ pol;
      hit = nrm2 && !nrm3;
      if (rdy_evt) begin m_drr = 1; m_ti = 1; end
      else if (data_rd) begin m_drr = 0; m_ti = 0; end
      if (&force_bits) m_fi = 1;
      else if (sel && rd_en) m_fi = 0;
      if (sel && wr_en && !wdata[7]) m_pend = 0;
      else if (hit && m_en) m_pend = 1;
      if (sel && wr_en) begin m_he = wdata[1]; m_en = wdata[7]; end
      h3 = h2; h2 = h1; h1 = pin;
    end
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] v, string tag);
    sel = 1; wr_en = 1; wdata = v; cyc(tag); idle();
  endtask

  initial begin
    int cnt;
    cnt = 0;
    while (!done && cnt < 100000) begin @(posedge clk); cnt++; end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    idle(); mode = 0; gie = 0; pin = 0; pol = 0; rst = 1;
    @(negedge clk);
    cyc("R10 reset"); cyc("R10 reset");
    rst = 0;
    sel = 1; #1;
    chk("R10 reset view", rdata, 8'h00);
    cyc("R10 after reset");
    idle();

    // R4 / R9: only bits 7 and 1 writable
    wr(8'h7F, "R9 write");
    sel = 1; #1; chk("R9 read-only bits unchanged", rdata, 8'h02);
    cyc("R9 read"); idle();
    wr(8'h00, "R4 clear he");

    // R2 / R3: ready event then data read; collision
    rdy_evt = 1; cyc("R2 set"); idle();
    sel = 1; #1; chk("R2 R3 drr ti set", rdata, 8'h21); cyc("R3 view"); idle();
    rdy_evt = 1; data_rd = 1; cyc("R2 collision"); idle();
    sel = 1; #1; chk("R2 set wins", rdata, 8'h21); cyc("R2 view"); idle();
    data_rd = 1; cyc("R3 clear"); idle();
    sel = 1; #1; chk("R3 cleared", rdata, 8'h00); cyc("R3 view"); idle();

    // R8: transfer interrupt gating
    rdy_evt = 1; cyc("R8 ready"); idle();
    mode = 1; gie = 0; #1; chk("R8 gie off", {7'b0, irq}, 8'h00); cyc("R8");
    mode = 1; gie = 1; #1; chk("R8 both on", {7'b0, irq}, 8'h01); cyc("R8");
    data_rd = 1; cyc("R8 clr"); idle(); mode = 0; gie = 0;

    // R5: forced flag, clear by register read, set wins
    force_bits = 3'b110; cyc("R5 partial"); idle();
    #1; chk("R5 partial no set", {7'b0, irq}, 8'h00);
    force_bits = 3'b111; cyc("R5 set"); idle();
    sel = 1; rd_en = 1; force_bits = 3'b111; cyc("R5 read collision"); idle();
    sel = 1; #1; chk("R5 set wins", rdata, 8'h40);
    rd_en = 1; cyc("R5 read"); idle();
    sel = 1; #1; chk("R5 cleared", rdata, 8'h00); cyc("R5 view"); idle();

    // R7: falling polarity, settle with PI disabled first
    pin = 1; pol = 1;
    for (int k = 0; k < 5; k++) cyc("R7 settle");
    wr(8'h80, "R6 enable");
    pin = 0; cyc("R7 fall"); cyc("R7 wait1");
    #1; chk("R7 not yet", {7'b0, irq}, 8'h00);
    cyc("R7 wait2");
    sel = 1; #1; chk("R7 falling edge pending", rdata, 8'h80); cyc("R7 view"); idle();
    wr(8'h80, "R6 write1 keeps pending");
    sel = 1; #1; chk("R6 pending kept", rdata, 8'h80); cyc("R6 view"); idle();
    wr(8'h00, "R6 clear");
    sel = 1; #1; chk("R6 cleared", rdata, 8'h00); cyc("R6 view"); idle();
    wr(8'h80, "R6 re-enable");
    pin = 1; for (int k = 0; k < 4; k++) cyc("R7 rising ignored");
    sel = 1; #1; chk("R7 opposite edge ignored", rdata, 8'h00); cyc("R7 view"); idle();
    // clear coinciding with an edge: write 0 dominates
    pin = 0; cyc("R6 edge"); cyc("R6 edge");
    wr(8'h00, "R6 clear on edge");
    sel = 1; #1; chk("R6 clear dominates edge", rdata, 8'h00); cyc("R6 view"); idle();

    // Random traffic, rising polarity
    pol = 0; pin = 0;
    for (int k = 0; k < 5; k++) cyc("R7 settle");
    for (int k = 0; k < 3000; k++) begin
      sel     = ($urandom % 2) == 0;
      wr_en   = ($urandom % 4) == 0;
      rd_en   = ($urandom % 3) == 0;
      wdata   = 8'($urandom);
      data_rd = ($urandom % 5) == 0;
      rdy_evt = ($urandom % 6) == 0;
      force_bits = (($urandom % 10) == 0) ? 3'b111 : 3'($urandom);
      mode    = ($urandom % 2) == 0;
      gie     = ($urandom % 2) == 0;
      if (($urandom % 3) == 0) pin = ~pin;
      cyc("R1 R2 R3 R5 R6 R7 R8 random");
    end
    idle();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule